// File: doc/BRIEF.md
# Partitioned Packed Integer SIMD ALU

This block is a 128-bit integer SIMD execution unit that treats each operand as a row of independent packed lanes. One lane-size code picks 16 lanes of 8 bits, 8 of 16, 4 of 32 or 2 of 64. The same row of lane units then runs one operation across every lane at once. No carry or borrow ever crosses from one lane into the next.

The operation set covers wrapping add and subtract, saturating add and subtract, per-lane minimum and maximum, absolute difference, and a pass operation. A sign select sets how lanes are read for clamping, comparisons and extension. The second operand can come from the vector input. It can also come from a scalar whose low lane-width bits are copied into every lane. A per-lane enable mask predicates the operation, and disabled lanes keep the bits of the first operand.

Alongside the packed result, the unit forms a horizontal 64-bit sum of the enabled result lanes. Both outputs are registered and appear, with a valid flag, one clock after the request.

Top module: `simd_alu`

## Requirements
- R1: `res_valid` rises in the cycle after a clock edge that sampled `req_valid` high, and is low in the cycle after an edge that sampled it low. `res_data` and `res_sum` change only after a sampled request and otherwise hold their values. Reset clears all three outputs to zero.
- R2: `lane_sz` 0, 1, 2 and 3 select lane widths of 8, 16, 32 and 64 bits. Lane i occupies bits [i*W +: W]. A carry or borrow never passes between lanes, so an 8-bit lane holding 0xFF plus 1 gives 0x00 and leaves its neighbours untouched.
- R3: Opcode 0 is a wrapping add and opcode 1 is a wrapping subtract (first minus second), each taken modulo 2^W per lane.
- R4: Opcode 2 is a saturating add and opcode 3 is a saturating subtract. When `is_signed`=1 the result is clamped to the range -2^(W-1) to 2^(W-1)-1. When `is_signed`=0 it is clamped to 0 to 2^W-1.
- R5: Opcode 4 gives the per-lane minimum and opcode 5 the per-lane maximum. Lanes are compared as two's complement when `is_signed`=1 and as unsigned when it is 0.
- R6: Opcode 6 gives the per-lane absolute difference |a-b| as an unsigned W-bit value, with a and b read according to `is_signed`.
- R7: Opcode 7 passes each enabled lane of the first operand through unchanged.
- R8: When `use_scalar`=1, the second operand of every lane is the low W bits of `scalar`, and `opnd_b` has no effect.
- R9: Lane i is enabled by `lane_en[i]`, and mask bits at or above the lane count are ignored. A disabled lane outputs the corresponding bits of `opnd_a` unchanged.
- R10: `res_sum` is the sum of the enabled result lanes. Each lane is sign-extended to 64 bits when `is_signed`=1 and zero-extended otherwise, and the total wraps modulo 2^64. It is 0 when no lane is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; inputs sampled on this edge |
| opnd_a | input | 128 | First packed operand |
| opnd_b | input | 128 | Second packed operand (vector mode) |
| scalar | input | 64 | Scalar operand for broadcast mode |
| lane_sz | input | 2 | Lane width code (8 << code bits) |
| opcode | input | 3 | Operation select |
| use_scalar | input | 1 | 1 = vector-scalar, 0 = vector-vector |
| is_signed | input | 1 | Signed lane interpretation |
| lane_en | input | 16 | Per-lane predicate mask |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_data | output | 128 | Packed result |
| res_sum | output | 64 | Horizontal sum of enabled result lanes |

## Verification
Every result, including the sum, the packed data and the valid flag, is due exactly one clock edge after the edge that sampled the request. The bench therefore drives a request on a falling edge and compares all three outputs on the next falling edge, half a period after the register has loaded. To check that results hold when no request is present, the bench drops the request, scrambles the inputs and compares again one edge later against the previous expected values. Expected packed results and sums come from a lane-by-lane reference model that uses wide signed arithmetic.

// File: rtl/simd_pkg.sv
package simd_pkg;
   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_ADDS = 3'd2,
      OP_SUBS = 3'd3,
      OP_MIN  = 3'd4,
      OP_MAX  = 3'd5,
      OP_ADIF = 3'd6,
      OP_PASS = 3'd7
   } simd_op_e;

   localparam int SUM_W   = 64;
   localparam int N_SIZES = 4;
endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
   import simd_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  simd_op_e     op,
   input  logic         sgn,
   output logic [W-1:0] y
);
   localparam int XW = W + 2;

   logic signed [XW-1:0] ea, eb, add_x, sub_x, hi_x, lo_x;
   logic [W-1:0] sat_add, sat_sub, abs_d;
   logic a_lt_b;

   // two guard bits make every sum and difference exact
   assign ea    = $signed({{2{sgn & a[W-1]}}, a});
   assign eb    = $signed({{2{sgn & b[W-1]}}, b});
   assign add_x = ea + eb;
   assign sub_x = ea - eb;
   assign hi_x  = sgn ? $signed({3'b000, {(W-1){1'b1}}}) : $signed({2'b00, {W{1'b1}}});
   assign lo_x  = sgn ? $signed({3'b111, {(W-1){1'b0}}}) : '0;
   assign a_lt_b = ea < eb;

   always_comb begin
      if (add_x > hi_x)      sat_add = hi_x[W-1:0];
      else if (add_x < lo_x) sat_add = lo_x[W-1:0];
      else                   sat_add = add_x[W-1:0];
      if (sub_x > hi_x)      sat_sub = hi_x[W-1:0];
      else if (sub_x < lo_x) sat_sub = lo_x[W-1:0];
      else                   sat_sub = sub_x[W-1:0];
      abs_d = a_lt_b ? (b - a) : (a - b);
   end

   always_comb begin
      unique case (op)
         OP_ADD:  y = add_x[W-1:0];
         OP_SUB:  y = sub_x[W-1:0];
         OP_ADDS: y = sat_add;
         OP_SUBS: y = sat_sub;
         OP_MIN:  y = a_lt_b ? a : b;
         OP_MAX:  y = a_lt_b ? b : a;
         OP_ADIF: y = abs_d;
         default: y = a;
      endcase
   end
endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
   import simd_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int W      = 8
) (
   input  logic [DATA_W-1:0]   a,
   input  logic [DATA_W-1:0]   b,
   input  simd_op_e            op,
   input  logic                sgn,
   input  logic [DATA_W/W-1:0] en,
   output logic [DATA_W-1:0]   res,
   output logic [SUM_W-1:0]    sum
);
   localparam int NL = DATA_W / W;

   if (W > SUM_W || (DATA_W % W) != 0) begin : g_bad_w
      $error("simd_lane_bank: lane width must divide DATA_W and fit the sum");
   end

   logic [W-1:0] lane_y [NL];
   logic [W-1:0] lane_r [NL];

   for (genvar i = 0; i < NL; i++) begin : g_lane
      simd_lane_alu #(.W(W)) u_lane (
         .a   (a[i*W +: W]),
         .b   (b[i*W +: W]),
         .op  (op),
         .sgn (sgn),
         .y   (lane_y[i])
      );
      assign lane_r[i]     = en[i] ? lane_y[i] : a[i*W +: W];
      assign res[i*W +: W] = lane_r[i];
   end

   always_comb begin
      sum = '0;
      for (int i = 0; i < NL; i++) begin
         if (en[i]) begin
            if (sgn) sum = sum + SUM_W'($signed(lane_r[i]));
            else     sum = sum + SUM_W'(lane_r[i]);
         end
      end
   end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
   import simd_pkg::*;
#(
   parameter int DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [SUM_W-1:0]  scalar,
   input  logic [1:0]        lane_sz,
   input  logic [2:0]        opcode,
   input  logic              use_scalar,
   input  logic              is_signed,
   input  logic [DATA_W/8-1:0] lane_en,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic [SUM_W-1:0]  res_sum
);
   localparam int MAX_LANES = DATA_W / 8;

   if (DATA_W < SUM_W || (DATA_W % SUM_W) != 0) begin : g_bad_data_w
      $error("simd_alu: DATA_W must be a multiple of 64");
   end

   simd_op_e          op;
   logic [DATA_W-1:0] bank_res [N_SIZES];
   logic [SUM_W-1:0]  bank_sum [N_SIZES];

   assign op = simd_op_e'(opcode);

   for (genvar g = 0; g < N_SIZES; g++) begin : g_size
      localparam int W  = 8 << g;
      localparam int NL = DATA_W / W;
      logic [DATA_W-1:0] b_sel;

      assign b_sel = use_scalar ? {NL{scalar[W-1:0]}} : opnd_b;

      simd_lane_bank #(.DATA_W(DATA_W), .W(W)) u_bank (
         .a   (opnd_a),
         .b   (b_sel),
         .op  (op),
         .sgn (is_signed),
         .en  (lane_en[NL-1:0]),
         .res (bank_res[g]),
         .sum (bank_sum[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
         res_sum   <= '0;
      end else begin
         res_valid <= req_valid;
         if (req_valid) begin
            res_data <= bank_res[lane_sz];
            res_sum  <= bank_sum[lane_sz];
         end
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid); // R1
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!res_valid && $stable(res_data) && $stable(res_sum))); // R1
   AST_MASK_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && lane_en == '0) |=> (res_data == $past(opnd_a) && res_sum == '0)); // R9
   AST_UNS_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && opcode == 3'(OP_MIN) && !is_signed && lane_sz == 2'd3 && lane_en[0])
      |=> (res_data[63:0] <= $past(opnd_a[63:0]))); // R5
   AST_UNS_SAT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && opcode == 3'(OP_ADDS) && !is_signed && lane_sz == 2'd3 && lane_en[0])
      |=> (res_data[63:0] >= $past(opnd_a[63:0]))); // R4

   initial begin
      if (MAX_LANES < 2) $error("simd_alu: too few lanes");
   end
endmodule

// File: tb/sim_simd_alu.sv
module sim_simd_alu;
   localparam int PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [127:0] opnd_a = '0, opnd_b = '0;
   logic [63:0]  scalar = '0;
   logic [1:0]   lane_sz = '0;
   logic [2:0]   opcode = '0;
   logic         use_scalar = 1'b0, is_signed = 1'b0;
   logic [15:0]  lane_en = '0;
   logic         res_valid;
   logic [127:0] res_data;
   logic [63:0]  res_sum;

   int checks = 0;
   int errors = 0;
   logic [127:0] exp_r;
   logic [63:0]  exp_s;

   always #(PERIOD/2) clk = ~clk;

   simd_alu u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .scalar(scalar), .lane_sz(lane_sz), .opcode(opcode), .use_scalar(use_scalar),
      .is_signed(is_signed), .lane_en(lane_en), .res_valid(res_valid),
      .res_data(res_data), .res_sum(res_sum)
   );

   function automatic logic signed [67:0] sx(input logic [127:0] v, input int w, input logic sg);
      logic signed [67:0] r;
      r = $signed({1'b0, v[66:0]});
      if (sg && v[w-1]) r = r - (68'sd1 <<< w);
      return r;
   endfunction

   function automatic void ref_op(input logic [127:0] a, b, input logic [63:0] sc,
                                  input logic [1:0] sz, input logic [2:0] op,
                                  input logic vs, sg, input logic [15:0] en,
                                  output logic [127:0] r, output logic [63:0] s);
      int w, n;
      logic [127:0] lm, la, lb, lane;
      logic signed [67:0] x, y, t, hi, lo;
      w = 8 << sz;
      n = 128 / w;
      lm = (128'd1 << w) - 128'd1;
      r = a;
      s = '0;
      hi = sg ? (68'sd1 <<< (w-1)) - 68'sd1 : (68'sd1 <<< w) - 68'sd1;
      lo = sg ? -(68'sd1 <<< (w-1)) : 68'sd0;
      for (int i = 0; i < n; i++) begin
         la = (a >> (i*w)) & lm;
         lb = vs ? ({64'd0, sc} & lm) : ((b >> (i*w)) & lm);
         x = sx(la, w, sg);
         y = sx(lb, w, sg);
         case (op)
            3'd0: t = x + y;
            3'd1: t = x - y;
            3'd2: t = x + y;
            3'd3: t = x - y;
            3'd4: t = (x < y) ? x : y;
            3'd5: t = (x < y) ? y : x;
            3'd6: t = (x < y) ? y - x : x - y;
            default: t = x;
         endcase
         if (op == 3'd2 || op == 3'd3) begin
            if (t > hi) t = hi;
            if (t < lo) t = lo;
         end
         if (en[i]) begin
            lane = 128'(t) & lm;
            r = (r & ~(lm << (i*w))) | (lane << (i*w));
            if (sg) s = s + 64'(sx(lane, w, 1'b1));
            else    s = s + lane[63:0];
         end
      end
   endfunction

   function automatic string rtag(input logic [2:0] op);
      case (op)
         3'd0, 3'd1: return "R3";
         3'd2, 3'd3: return "R4";
         3'd4, 3'd5: return "R5";
         3'd6:       return "R6";
         default:    return "R7";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive at a falling edge, compare at the next falling edge
   task automatic run(input string tag, input logic [127:0] a, b, input logic [63:0] sc,
                      input logic [1:0] sz, input logic [2:0] op, input logic vs, sg,
                      input logic [15:0] en);
      opnd_a = a; opnd_b = b; scalar = sc; lane_sz = sz; opcode = op;
      use_scalar = vs; is_signed = sg; lane_en = en; req_valid = 1'b1;
      ref_op(a, b, sc, sz, op, vs, sg, en, exp_r, exp_s);
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " data"}, res_data, exp_r);
      chk({tag, " sum R10"}, {64'd0, res_sum}, {64'd0, exp_s});
      chk({tag, " valid R1"}, {127'd0, res_valid}, 128'd1);
   endtask

   initial begin
      #(PERIOD * 200000);
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [127:0] ra, rb;
      repeat (3) @(negedge clk);
      chk("R1 reset data", res_data, '0);
      chk("R1 reset sum", {64'd0, res_sum}, '0);
      chk("R1 reset valid", {127'd0, res_valid}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: 0xFF+1 in lane 0 wraps without touching lane 1
      run("R2 lane cut", 128'h00FF, 128'h0001, '0, 2'd0, 3'd0, 1'b0, 1'b0, 16'hFFFF);
      chk("R2 exact", res_data, 128'h0000);
      run("R2 lane cut 16", {16{8'hFF}}, 128'h1, '0, 2'd1, 3'd0, 1'b0, 1'b0, 16'hFFFF);
      // R4 corners
      run("R4 signed hi", {16{8'h7F}}, {16{8'h01}}, '0, 2'd0, 3'd2, 1'b0, 1'b1, 16'hFFFF);
      chk("R4 clamp 7F", res_data, {16{8'h7F}});
      run("R4 signed lo", {8{16'h8000}}, {8{16'h0001}}, '0, 2'd1, 3'd3, 1'b0, 1'b1, 16'h00FF);
      run("R4 unsigned hi", {4{32'hFFFF_FFFF}}, {4{32'h2}}, '0, 2'd2, 3'd2, 1'b0, 1'b0, 16'h000F);
      run("R4 unsigned lo", {2{64'h5}}, {2{64'h9}}, '0, 2'd3, 3'd3, 1'b0, 1'b0, 16'h0003);
      chk("R4 clamp 0", res_data, '0);
      // R6 signed extreme difference
      run("R6 extreme", {16{8'h80}}, {16{8'h7F}}, '0, 2'd0, 3'd6, 1'b0, 1'b1, 16'hFFFF);
      // R8 broadcast: opnd_b ignored
      run("R8 scalar", {8{16'h0100}}, {8{16'hDEAD}}, 64'h1234_5678_9ABC_0003, 2'd1, 3'd0,
          1'b1, 1'b0, 16'hFFFF);
      chk("R8 exact", res_data, {8{16'h0103}});
      // R9 mask: alternating lanes, upper bits ignored for wide lanes
      run("R9 mask alt", {16{8'h10}}, {16{8'h01}}, '0, 2'd0, 3'd0, 1'b0, 1'b0, 16'h5555);
      run("R9 mask upper", {2{64'h7}}, {2{64'h1}}, '0, 2'd3, 3'd0, 1'b0, 1'b0, 16'hFFFD);
      run("R9 none", {4{32'hCAFE_F00D}}, {4{32'h1}}, '0, 2'd2, 3'd0, 1'b0, 1'b1, 16'h0000);
      // R10 signed sum of negatives wraps
      run("R10 signed sum", {2{64'hFFFF_FFFF_FFFF_FFFF}}, '0, '0, 2'd3, 3'd7, 1'b0, 1'b1, 16'h0003);
      chk("R10 exact", {64'd0, res_sum}, {64'd0, 64'hFFFF_FFFF_FFFF_FFFE});

      // R1 hold: no request, inputs scrambled
      opnd_a = '1; opnd_b = '1; opcode = 3'd1; lane_en = '1;
      @(negedge clk);
      chk("R1 hold data", res_data, exp_r);
      chk("R1 hold sum", {64'd0, res_sum}, {64'd0, exp_s});
      chk("R1 idle valid", {127'd0, res_valid}, '0);

      void'($urandom(32'd1789));
      for (int k = 0; k < 400; k++) begin
         logic [2:0] op;
         logic [1:0] sz;
         ra = {$urandom, $urandom, $urandom, $urandom};
         rb = {$urandom, $urandom, $urandom, $urandom};
         if ($urandom_range(3) == 0) ra = {16{8'h80 | 8'($urandom_range(1))}} ^ {16{8'($urandom_range(1) * 8'h7F)}};
         if ($urandom_range(3) == 0) rb = {16{8'hFF}};
         op = 3'($urandom_range(7));
         sz = 2'($urandom_range(3));
         run(rtag(op), ra, rb, {$urandom, $urandom}, sz, op, 1'($urandom_range(1)),
             1'($urandom_range(1)), 16'($urandom));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule